// File: doc/BRIEF.md
# Single-Step CPU Boot Loader

This block lets a host push a boot program into an 8-bit CPU one bus cycle at a time. The host offers bytes on a valid/ready input. Each accepted byte is held on an 8-bit data output, and after a programmable settling interval the block pulses a dedicated CPU clock output high and then low. Only when the low phase has run out does it take the next byte. The CPU therefore advances exactly one cycle per supplied byte. Booting this way is far slower than free-running operation, but it needs nothing beyond nine output lines.

The data lines go to a pad buffer at the chip top. A select input sets the pad's output enable, which is registered here, so the bus can be floated whenever the CPU should see some other source. The CPU clock comes straight from a flip-flop, so no combinational glitch can reach it.

A control FSM has four states. IDLE raises ready and waits for a byte. On a handshake it moves to SETUP (data stable, clock low), then HIGH (clock high), then LOW (clock low), and from there back to IDLE. Each of SETUP, HIGH and LOW leaves when its phase counter reaches the length set for that phase. A synchronous reset forces IDLE from any state.

Top module: `cpu_step_loader`

## Requirements
- R1: The byte on `in_data` in the handshake cycle (`in_valid` and `in_ready` both high) is what `cpu_data` shows while `cpu_clk` is high. Changes on `in_data` after that handshake have no effect on `cpu_data` until the next handshake.
- R2: `cpu_clk` rises exactly `SETUP_CYC` clock cycles after the edge that completes the handshake. `cpu_data` does not change in that interval.
- R3: `cpu_clk` stays high for exactly `HIGH_CYC` cycles.
- R4: `in_ready` goes low on the handshake edge and stays low for `SETUP_CYC+HIGH_CYC+LOW_CYC` cycles. This means it returns only after `cpu_clk` has been low for `LOW_CYC` cycles.
- R5: Each accepted byte produces exactly one `cpu_clk` pulse, and `cpu_clk` never rises without an accepted byte.
- R6: `cpu_data_oe` (1 = drive the data pads, 0 = high impedance) equals `bus_sel` from the previous cycle. `bus_sel` has no effect on handshake or clock timing.
- R7: After a cycle with `rst` high, `cpu_clk` is 0, `cpu_data_oe` is 0 and `in_ready` is 1. Any transfer in progress is abandoned and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block can accept a byte |
| bus_sel | input | 1 | Request to drive the CPU data pads |
| cpu_data | output | 8 | Byte presented to the CPU data bus |
| cpu_data_oe | output | 1 | Pad output enable for `cpu_data` |
| cpu_clk | output | 1 | Registered CPU clock |

## Verification
The hardest case to reach from the ports is a reset that lands after a byte has been accepted but before its clock pulse. Such a byte must disappear without a pulse, and the ready and enable outputs must return to their reset values. The bench runs every byte value with several inter-byte gaps and a changing select pattern. It then accepts one more byte and asserts reset two cycles into its setup phase. A per-cycle model checks that no pulse follows and that the pulse count stays equal to the number of completed bytes.

// File: rtl/stepld_pkg.sv
package stepld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } step_state_t;
endpackage

// File: rtl/stepld_phase_counter.sv
module stepld_phase_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/stepld_fsm.sv
module stepld_fsm
    import stepld_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 2,
    parameter int LOW_CYC   = 2,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [CW-1:0] count,
    output step_state_t   state,
    output step_state_t   state_nx,
    output logic          cnt_clear,
    output logic          load,
    output logic          ready
);
    localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HIGH_END  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] LOW_END   = CW'(LOW_CYC - 1);

    logic phase_done;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid)   state_nx = ST_SETUP;
            ST_SETUP: if (phase_done) state_nx = ST_HIGH;
            ST_HIGH:  if (phase_done) state_nx = ST_LOW;
            ST_LOW:   if (phase_done) state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phase_done = 1'b0;
        ready      = 1'b0;
        unique case (state)
            ST_IDLE:  ready      = 1'b1;
            ST_SETUP: phase_done = (count == SETUP_END);
            ST_HIGH:  phase_done = (count == HIGH_END);
            ST_LOW:   phase_done = (count == LOW_END);
        endcase
        load      = ready && in_valid;
        cnt_clear = ready || phase_done;
    end
endmodule

// File: rtl/stepld_pad_stage.sv
module stepld_pad_stage
    import stepld_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  step_state_t   state_nx,
    input  logic          bus_sel,
    output logic [DW-1:0] cpu_data,
    output logic          cpu_data_oe,
    output logic          cpu_clk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_data <= '0;
        end else if (load) begin
            cpu_data <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_clk     <= 1'b0;
            cpu_data_oe <= 1'b0;
        end else begin
            cpu_clk     <= (state_nx == ST_HIGH);
            cpu_data_oe <= bus_sel;
        end
    end
endmodule

// File: rtl/cpu_step_loader.sv
module cpu_step_loader
    import stepld_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 2,
    parameter int LOW_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          bus_sel,
    output logic [DW-1:0] cpu_data,
    output logic          cpu_data_oe,
    output logic          cpu_clk
);
    localparam int MAX_A   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int MAX_LEN = (MAX_A > LOW_CYC) ? MAX_A : LOW_CYC;
    localparam int CW      = $clog2(MAX_LEN) + 1;

    step_state_t   state, state_nx;
    logic          cnt_clear, load;
    logic [CW-1:0] count;

    stepld_phase_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .count (count)
    );

    stepld_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .LOW_CYC   (LOW_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .count     (count),
        .state     (state),
        .state_nx  (state_nx),
        .cnt_clear (cnt_clear),
        .load      (load),
        .ready     (in_ready)
    );

    stepld_pad_stage #(.DW(DW)) u_pad (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_data   (in_data),
        .state_nx    (state_nx),
        .bus_sel     (bus_sel),
        .cpu_data    (cpu_data),
        .cpu_data_oe (cpu_data_oe),
        .cpu_clk     (cpu_clk)
    );
endmodule

// File: rtl/cpu_step_loader_chk.sv
module cpu_step_loader_chk #(
    parameter int DW       = 8,
    parameter int HIGH_CYC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          bus_sel,
    input logic [DW-1:0] cpu_data,
    input logic          cpu_data_oe,
    input logic          cpu_clk
);
    logic        rst_q  = 1'b0;
    logic [15:0] hi_run = '0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || !cpu_clk) hi_run <= '0;
        else                 hi_run <= hi_run + 1'b1;
    end

    // R2: data settled in the cycle before the rising clock edge
    a_r2_setup_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) |-> $stable(cpu_data));

    // R1: data held while a transfer is in flight
    a_r1_data_held: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && $past(!in_ready)) |-> $stable(cpu_data));

    a_r3_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk) |-> (hi_run == 16'(HIGH_CYC)));

    a_r4_busy_in_high: assert property (@(posedge clk) disable iff (rst)
        cpu_clk |-> !in_ready);

    a_r4_low_after_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk) |-> !in_ready);

    a_r5_one_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r6_oe_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cpu_data_oe == $past(bus_sel)));

    always_comb begin
        if (rst_q) begin
            a_r7_reset_state: assert (!cpu_clk && !cpu_data_oe && in_ready);
        end
    end
endmodule

bind cpu_step_loader cpu_step_loader_chk #(
    .DW       (DW),
    .HIGH_CYC (HIGH_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .bus_sel     (bus_sel),
    .cpu_data    (cpu_data),
    .cpu_data_oe (cpu_data_oe),
    .cpu_clk     (cpu_clk)
);

// File: tb/cpu_step_loader_tb.sv
module cpu_step_loader_tb;
    localparam int S = 2;
    localparam int H = 1;
    localparam int L = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       bus_sel = 1'b0;
    logic       in_ready;
    logic [7:0] cpu_data;
    logic       cpu_data_oe;
    logic       cpu_clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acc_cyc = -1000;
    logic [7:0] acc_byte = 8'h00;
    logic sel_prev = 1'b0;
    logic clk_prev = 1'b0;
    int accepted = 0;
    int aborted = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_step_loader #(
        .DW(8), .SETUP_CYC(S), .HIGH_CYC(H), .LOW_CYC(L)
    ) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .bus_sel(bus_sel), .cpu_data(cpu_data),
        .cpu_data_oe(cpu_data_oe), .cpu_clk(cpu_clk)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // per-cycle reference model, sampled on the falling edge
    always @(negedge clk) begin
        int  k;
        bit  e_clk, e_rdy;
        if (cyc > 0 && !done) begin
            k     = cyc - acc_cyc;
            e_clk = (k >= S + 1) && (k <= S + H);
            e_rdy = !((k >= 1) && (k <= S + H + L));
            chk(cpu_clk == e_clk, "R2/R3/R5 cpu_clk", cpu_clk, e_clk);
            chk(in_ready == e_rdy, "R4/R7 in_ready", in_ready, e_rdy);
            chk(cpu_data_oe == sel_prev, "R6/R7 cpu_data_oe", cpu_data_oe, sel_prev);
            if (e_clk)
                chk(cpu_data == acc_byte, "R1 cpu_data", cpu_data, acc_byte);
            if (cpu_clk && !clk_prev) pulses++;
        end
        clk_prev = cpu_clk;
        if (rst) begin
            k = cyc - acc_cyc;
            if (k >= 1 && k <= S) aborted++;
            acc_cyc  = -1000;
            sel_prev = 1'b0;
        end else begin
            if (in_valid && in_ready) begin
                acc_cyc  = cyc;
                acc_byte = in_data;
                accepted++;
            end
            sel_prev = bus_sel;
        end
        cyc++;
    end

    task automatic send(input logic [7:0] b, input int gap);
        in_valid = 1'b1;
        in_data  = b;
        bus_sel  = (b % 5) != 0;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = ~b;       // R1: later input changes must be ignored
        bus_sel  = b[0] ^ b[2];
        repeat (gap) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R7: reset state seen by the model in the cycles above
        for (int b = 0; b < 256; b++) begin
            send(8'(b), b % 3);
        end
        // R7: reset during setup of an accepted byte
        in_valid = 1'b1;
        in_data  = 8'hA5;
        bus_sel  = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        bus_sel = 1'b0;
        repeat (S + H + L + 4) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        chk(aborted == 1, "R7 aborted transfers", aborted, 1);
        chk(pulses == accepted - aborted, "R5 pulse count", pulses, accepted - aborted);
        chk(accepted == 257, "R4 accepted bytes", accepted, 257);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule